// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block is a free-standing watchdog for a system-on-chip. A down-counter runs on a separate low-speed clock after a programmable power-of-two prescaler, so it keeps timing even if the bus clock stalls. When the counter runs out, the block raises a system reset pulse in the bus clock domain and sets a sticky cause flag that stays set until an external clear input is asserted.

Software uses a small synchronous register bus. It cannot write to the block freely: starting, refreshing and unlocking happen only when particular 16-bit key values are written. Once started, nothing stops the watchdog. The prescaler and reload registers are write-protected unless they have been unlocked. Each configuration register has a busy flag that stays set while its new value is carried into the low-speed domain.

An optional refresh window catches software that refreshes too early. When a refresh arrives while the count is still above the window value, the block treats it as a fault. A hardware-start input starts the watchdog at reset with no key write.

Top module: `kwd_top`

## Requirements
- R1: After reset the counter holds all-ones and does not count, `wdg_rst` and `wdg_cause` are 0, the prescaler reads 0, reload and window read all-ones, and status reads 0.
- R2: Writing 16'hCCCC to the key register (address 0) starts counting from all-ones. With prescaler code 0, expiry comes after 2^CNT_W * 4 low-speed cycles.
- R3: If `hw_start` is 1 while reset is applied, the watchdog runs from reset with no key write.
- R4: Once the watchdog runs, no key value stops it. Writes of other key values leave it running and expiring.
- R5: Writing 16'hAAAA to the key register loads the counter with the effective reload value R and restarts the prescaler. The next expiry comes (R+1)*div low-speed cycles later. After each expiry the counter reloads R by itself, so expiries repeat with that period, and regular refreshes prevent any expiry.
- R6: The prescaler register (address 1, bits [2:0]) selects div = 4 << code for codes 0 to 6. Code 7 also gives 256.
- R7: Writing 16'h5555 to the key register unlocks the prescaler and reload (address 2, 12 bits) registers. Writes to them while locked are ignored: the readback does not change and no busy flag sets.
- R8: Writing 16'hAAAA or 16'hCCCC locks the prescaler and reload registers again. Any other key value leaves the lock state unchanged.
- R9: Status (address 4) bits 0, 1 and 2 are the busy flags for prescaler, reload and window. A flag is set from the cycle after an accepted write until the value is in effect. A write to a register whose flag is set is ignored.
- R10: The window register (address 3) is never locked. A refresh while the running count is greater than the window value causes an expiry and reloads the counter. When the window value is all-ones the check never fires.
- R11: Each expiry drives `wdg_rst` high for exactly RST_CYCLES bus clock cycles.
- R12: `wdg_cause` rises together with `wdg_rst` and stays 1 until `cause_clr` is sampled high with no new expiry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset, used in both clock domains |
| lsi_clk | input | 1 | Low-speed watchdog clock |
| hw_start | input | 1 | Starts the watchdog at reset when high |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, together with bus_en |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| cause_clr | input | 1 | Clears the sticky cause flag |
| wdg_rst | output | 1 | System reset pulse |
| wdg_cause | output | 1 | Sticky flag: the watchdog caused a reset |

## Verification
The bench builds the block with a 6-bit counter and a 4-cycle reset pulse, and runs the low-speed clock at a quarter of the bus clock. A full-scale timeout is then about a thousand bus cycles. This makes it possible to sweep every prescaler code, each with two reload values, and to check the exact period between successive expiries. The same settings leave room to reach the early and late sides of the refresh window with count values chosen by arithmetic, as well as the lock, busy-ignore and hardware-start cases.

// File: rtl/kwd_pkg.sv
// Package: key values, register addresses and command indices shared by the
// watchdog modules. Assumes a 16-bit key field.
package kwd_pkg;
    localparam int DATA_W = 16;
    localparam logic [DATA_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [DATA_W-1:0] KEY_START   = 16'hCCCC;
    localparam logic [DATA_W-1:0] KEY_UNLOCK  = 16'h5555;

    typedef enum logic [2:0] {
        ADR_KEY  = 3'd0,
        ADR_PRE  = 3'd1,
        ADR_RLD  = 3'd2,
        ADR_WIN  = 3'd3,
        ADR_STAT = 3'd4
    } kwd_addr_e;

    localparam int CMD_START = 0;
    localparam int CMD_REFR  = 1;
    localparam int N_CMD     = 2;
endpackage

// File: rtl/kwd_sync.sv
// Module: multi-flop synchronizer for one level signal.
// Assumes the input changes slowly compared with the destination clock.
module kwd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Move the input along the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/kwd_cfg_chan.sv
// Module: one configuration register with a clock-domain crossing.
// The bus side keeps the value and flips a request toggle. The low-speed
// side copies the value once it sees the toggle, then echoes it back.
// Busy holds from the accepted write until the echo returns. The held
// value stays stable while busy, so the copy is safe.
module kwd_cfg_chan #(
    parameter int              W       = 12,
    parameter logic [W-1:0]    RST_VAL = '0,
    parameter int              STAGES  = 2
) (
    input  logic         clk,
    input  logic         lsi_clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] bus_val,
    output logic         busy,
    output logic [W-1:0] lsi_val
);
    logic [W-1:0] hold_q;
    logic         req_q;
    logic         ack_q;
    logic         req_s;
    logic         ack_s;

    // Bus side: accept a write only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= RST_VAL;
            req_q  <= 1'b0;
        end else if (wr_en && !busy) begin
            hold_q <= wr_data;
            req_q  <= ~req_q;
        end
    end

    kwd_sync #(.STAGES(STAGES)) u_req_sync (
        .clk(lsi_clk), .rst_n(rst_n), .d(req_q), .q(req_s)
    );
    kwd_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_q), .q(ack_s)
    );

    // Low-speed side: copy the held value on a new request, then acknowledge.
    always_ff @(posedge lsi_clk) begin
        if (!rst_n) begin
            lsi_val <= RST_VAL;
            ack_q   <= 1'b0;
        end else if (req_s != ack_q) begin
            lsi_val <= hold_q;
            ack_q   <= req_s;
        end
    end

    assign busy    = (req_q != ack_s);
    assign bus_val = hold_q;

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(hold_q)); // R9
endmodule

// File: rtl/kwd_lsi_core.sv
// Module: prescaler, down-counter and window check in the low-speed domain.
// Takes synchronized command toggles and turns them into one-cycle events.
// Reports each expiry by flipping exp_tgl.
// Assumes the configuration inputs only change between low-speed edges
// through kwd_cfg_chan.
module kwd_lsi_core #(
    parameter int CNT_W        = 12,
    parameter int PRE_W        = 3,
    parameter int DIV_MIN_LOG2 = 2,
    parameter int DIV_STEPS    = 7
) (
    input  logic             lsi_clk,
    input  logic             rst_n,
    input  logic             hw_start,
    input  logic             start_tgl_s,
    input  logic             ref_tgl_s,
    input  logic [PRE_W-1:0] pre_code,
    input  logic [CNT_W-1:0] rld_val,
    input  logic [CNT_W-1:0] win_val,
    output logic             exp_tgl
);
    localparam int PCNT_W = DIV_MIN_LOG2 + DIV_STEPS - 1;

    logic              start_d, ref_d;
    logic              start_evt, ref_evt;
    logic              run_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PCNT_W-1:0] pre_q;
    logic [PCNT_W-1:0] pre_last;
    logic              tick;
    logic              early_flt;
    logic              exp_q;
    int                div_log2;

    // Remember the previous toggle levels for edge detection.
    always_ff @(posedge lsi_clk) begin
        if (!rst_n) begin
            start_d <= 1'b0;
            ref_d   <= 1'b0;
        end else begin
            start_d <= start_tgl_s;
            ref_d   <= ref_tgl_s;
        end
    end

    assign start_evt = start_tgl_s ^ start_d;
    assign ref_evt   = ref_tgl_s ^ ref_d;

    // Work out the terminal prescaler count from the selected code.
    always_comb begin
        if (int'(pre_code) >= DIV_STEPS - 1) div_log2 = PCNT_W;
        else                                 div_log2 = DIV_MIN_LOG2 + int'(pre_code);
        pre_last = PCNT_W'((32'd1 << div_log2) - 32'd1);
    end

    assign tick      = (pre_q >= pre_last);
    assign early_flt = ref_evt && run_q && (cnt_q > win_val);

    // Handle the run state, the counter, the prescaler and the expiry.
    always_ff @(posedge lsi_clk) begin
        if (!rst_n) begin
            run_q <= hw_start;
            cnt_q <= '1;
            pre_q <= '0;
            exp_q <= 1'b0;
        end else begin
            if (start_evt) run_q <= 1'b1;
            if (ref_evt) begin
                cnt_q <= rld_val;
                pre_q <= '0;
                if (early_flt) exp_q <= ~exp_q;
            end else if (run_q) begin
                if (tick) begin
                    pre_q <= '0;
                    if (cnt_q == '0) begin
                        exp_q <= ~exp_q;
                        cnt_q <= rld_val;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    end

    assign exp_tgl = exp_q;

    AST_IDLE_FROZEN: assert property (@(posedge lsi_clk) disable iff (!rst_n)
        (!run_q && !ref_evt && !start_evt) |=> $stable(cnt_q)); // R1
    AST_CNT_STEP: assert property (@(posedge lsi_clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) - 1'b1) || (cnt_q == $past(rld_val)))); // R5
    AST_EARLY_FAULT: assert property (@(posedge lsi_clk) disable iff (!rst_n)
        early_flt |=> (exp_q != $past(exp_q))); // R10
endmodule

// File: rtl/kwd_rst_pulse.sv
// Module: bus-domain reset pulse and sticky cause flag.
// Synchronizes the expiry toggle and turns each edge into a pulse of
// RST_CYCLES cycles. Assumes expiries are spaced by more than a few bus
// cycles.
module kwd_rst_pulse #(
    parameter int RST_CYCLES = 16,
    parameter int STAGES     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic exp_tgl,
    input  logic cause_clr,
    output logic rst_o,
    output logic cause_o
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    logic          exp_s, exp_d, exp_evt;
    logic [CW-1:0] len_q;

    kwd_sync #(.STAGES(STAGES)) u_exp_sync (
        .clk(clk), .rst_n(rst_n), .d(exp_tgl), .q(exp_s)
    );

    assign exp_evt = exp_s ^ exp_d;

    // Edge-detect the expiry, time the pulse and keep the cause flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_d   <= 1'b0;
            len_q   <= '0;
            cause_o <= 1'b0;
        end else begin
            exp_d <= exp_s;
            if (exp_evt) begin
                len_q   <= CW'(RST_CYCLES);
                cause_o <= 1'b1;
            end else begin
                if (len_q != '0) len_q <= len_q - 1'b1;
                if (cause_clr)   cause_o <= 1'b0;
            end
        end
    end

    assign rst_o = (len_q != '0);

    AST_CAUSE_ON_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_o) |-> cause_o); // R12
    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_o && !cause_clr) |=> cause_o); // R12
    AST_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_o) && (RST_CYCLES > 1)) |=> rst_o); // R11
endmodule

// File: rtl/kwd_top.sv
// Module: keyed windowed watchdog top level.
// Decodes bus writes, keeps the unlock state, sends start and refresh
// commands as toggles into the low-speed domain, holds one crossing channel
// per configuration register, and returns the reset pulse.
// Assumes rst_n is held for several low-speed cycles.
module kwd_top #(
    parameter int CNT_W        = 12,
    parameter int PRE_W        = 3,
    parameter int DIV_MIN_LOG2 = 2,
    parameter int DIV_STEPS    = 7,
    parameter int RST_CYCLES   = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lsi_clk,
    input  logic        hw_start,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        cause_clr,
    output logic        wdg_rst,
    output logic        wdg_cause
);
    import kwd_pkg::*;

    logic             wr, key_wr;
    logic             unlock_q;
    logic [N_CMD-1:0] cmd_tgl_q;
    logic [N_CMD-1:0] cmd_tgl_s;
    logic             pre_wr, rld_wr, win_wr;
    logic             pre_busy, rld_busy, win_busy;
    logic [PRE_W-1:0] pre_bus, pre_lsi;
    logic [CNT_W-1:0] rld_bus, rld_lsi, win_bus, win_lsi;
    logic             exp_tgl;

    assign wr     = bus_en && bus_we;
    assign key_wr = wr && (bus_addr == ADR_KEY);
    assign pre_wr = wr && (bus_addr == ADR_PRE) && unlock_q;
    assign rld_wr = wr && (bus_addr == ADR_RLD) && unlock_q;
    assign win_wr = wr && (bus_addr == ADR_WIN);

    // Key decoding: the unlock state and the command toggles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlock_q  <= 1'b0;
            cmd_tgl_q <= '0;
        end else if (key_wr) begin
            if (bus_wdata == KEY_UNLOCK) unlock_q <= 1'b1;
            if (bus_wdata == KEY_START) begin
                unlock_q             <= 1'b0;
                cmd_tgl_q[CMD_START] <= ~cmd_tgl_q[CMD_START];
            end
            if (bus_wdata == KEY_REFRESH) begin
                unlock_q            <= 1'b0;
                cmd_tgl_q[CMD_REFR] <= ~cmd_tgl_q[CMD_REFR];
            end
        end
    end

    for (genvar g = 0; g < N_CMD; g++) begin : g_cmd_sync
        kwd_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(lsi_clk), .rst_n(rst_n), .d(cmd_tgl_q[g]), .q(cmd_tgl_s[g])
        );
    end

    kwd_cfg_chan #(.W(PRE_W), .RST_VAL('0), .STAGES(SYNC_STAGES)) u_pre_chan (
        .clk(clk), .lsi_clk(lsi_clk), .rst_n(rst_n), .wr_en(pre_wr),
        .wr_data(bus_wdata[PRE_W-1:0]), .bus_val(pre_bus), .busy(pre_busy),
        .lsi_val(pre_lsi)
    );
    kwd_cfg_chan #(.W(CNT_W), .RST_VAL('1), .STAGES(SYNC_STAGES)) u_rld_chan (
        .clk(clk), .lsi_clk(lsi_clk), .rst_n(rst_n), .wr_en(rld_wr),
        .wr_data(bus_wdata[CNT_W-1:0]), .bus_val(rld_bus), .busy(rld_busy),
        .lsi_val(rld_lsi)
    );
    kwd_cfg_chan #(.W(CNT_W), .RST_VAL('1), .STAGES(SYNC_STAGES)) u_win_chan (
        .clk(clk), .lsi_clk(lsi_clk), .rst_n(rst_n), .wr_en(win_wr),
        .wr_data(bus_wdata[CNT_W-1:0]), .bus_val(win_bus), .busy(win_busy),
        .lsi_val(win_lsi)
    );

    kwd_lsi_core #(
        .CNT_W(CNT_W), .PRE_W(PRE_W), .DIV_MIN_LOG2(DIV_MIN_LOG2), .DIV_STEPS(DIV_STEPS)
    ) u_core (
        .lsi_clk(lsi_clk), .rst_n(rst_n), .hw_start(hw_start),
        .start_tgl_s(cmd_tgl_s[CMD_START]), .ref_tgl_s(cmd_tgl_s[CMD_REFR]),
        .pre_code(pre_lsi), .rld_val(rld_lsi), .win_val(win_lsi), .exp_tgl(exp_tgl)
    );

    kwd_rst_pulse #(.RST_CYCLES(RST_CYCLES), .STAGES(SYNC_STAGES)) u_pulse (
        .clk(clk), .rst_n(rst_n), .exp_tgl(exp_tgl), .cause_clr(cause_clr),
        .rst_o(wdg_rst), .cause_o(wdg_cause)
    );

    // Read multiplexer: the held bus-side values and the busy flags.
    always_comb begin
        case (bus_addr)
            ADR_PRE:  bus_rdata = DATA_W'(pre_bus);
            ADR_RLD:  bus_rdata = DATA_W'(rld_bus);
            ADR_WIN:  bus_rdata = DATA_W'(win_bus);
            ADR_STAT: bus_rdata = DATA_W'({win_busy, rld_busy, pre_busy});
            default:  bus_rdata = '0;
        endcase
    end

    AST_LOCKED_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (bus_addr == ADR_PRE) && !unlock_q && !pre_busy) |=> !pre_busy); // R7
    AST_LOCKED_RLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (bus_addr == ADR_RLD) && !unlock_q && !rld_busy) |=> $stable(rld_bus)); // R7
endmodule

// File: tb/kwd_top_tb_top.sv
module kwd_top_tb_top;
    localparam int CW   = 6;
    localparam int RSTC = 4;
    localparam int FULL = (1 << CW) - 1;

    logic        clk = 0, lsi_clk = 0, rst_n = 0, hw_start = 0;
    logic        bus_en = 0, bus_we = 0, cause_clr = 0;
    logic [2:0]  bus_addr = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic        wdg_rst, wdg_cause;
    int          vecs = 0, miss = 0, cyc = 0;
    bit          done = 0;

    kwd_top #(.CNT_W(CW), .RST_CYCLES(RSTC)) dut_i (
        .clk(clk), .rst_n(rst_n), .lsi_clk(lsi_clk), .hw_start(hw_start),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cause_clr(cause_clr), .wdg_rst(wdg_rst), .wdg_cause(wdg_cause)
    );

    always #2 clk = ~clk;
    initial begin #1; forever #8 lsi_clk = ~lsi_clk; end
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            miss++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output int v);
        @(negedge clk);
        bus_addr = a; #1;
        v = int'(bus_rdata);
    endtask

    // Cycles until the next low-to-high change of wdg_rst, or -1.
    task automatic rise_after(input int limit, output int n);
        n = 0;
        while (wdg_rst && n < limit) begin step(); n++; end
        while (!wdg_rst && n < limit) begin step(); n++; end
        if (!wdg_rst) n = -1;
    endtask

    task automatic wait_idle(input string req);
        int v, n;
        n = 0;
        bus_rd(3'd4, v);
        while (v != 0 && n < 100) begin bus_rd(3'd4, v); n++; end
        chk(v == 0, req, v, 0);
    endtask

    task automatic do_reset(input logic hs);
        @(negedge clk);
        rst_n = 0; hw_start = hs;
        repeat (24) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic cfg(input int code, input int r);
        bus_wr(3'd0, 16'h5555);
        bus_wr(3'd1, 16'(code));
        wait_idle("R9");
        bus_wr(3'd2, 16'(r));
        wait_idle("R9");
        bus_wr(3'd0, 16'hAAAA);
    endtask

    initial begin
        int v, n, w, t0, ex, dv;
        do_reset(0);
        // R1 reset values and idle counter
        bus_rd(3'd1, v); chk(v == 0, "R1 pre", v, 0);
        bus_rd(3'd2, v); chk(v == FULL, "R1 rld", v, FULL);
        bus_rd(3'd3, v); chk(v == FULL, "R1 win", v, FULL);
        bus_rd(3'd4, v); chk(v == 0, "R1 stat", v, 0);
        chk(!wdg_rst && !wdg_cause, "R1 outs", {wdg_rst, wdg_cause}, 0);
        rise_after(1500, n); chk(n == -1, "R1 idle", n, -1);

        // R2 start key, full-scale timeout
        bus_wr(3'd0, 16'hCCCC);
        ex = (FULL + 1) * 4 * 4;
        rise_after(2000, n); chk(n >= ex && n <= ex + 36, "R2 timeout", n, ex);
        chk(wdg_cause == 1, "R12 cause set", wdg_cause, 1);
        w = 1; step();
        while (wdg_rst && w < 50) begin w++; step(); end
        chk(w == RSTC, "R11 width", w, RSTC);
        repeat (50) step();
        chk(wdg_cause == 1, "R12 sticky", wdg_cause, 1);
        @(negedge clk); cause_clr = 1; @(negedge clk); cause_clr = 0; #1;
        chk(wdg_cause == 0, "R12 clear", wdg_cause, 0);

        // R4 other keys do not stop it
        bus_wr(3'd0, 16'h0000);
        bus_wr(3'd0, 16'h1234);
        rise_after(2000, n); chk(n > 0, "R4 still running", n, 1);

        // R7 locked writes ignored
        bus_wr(3'd1, 16'd5);
        bus_rd(3'd4, v); chk(v == 0, "R7 no busy", v, 0);
        bus_rd(3'd1, v); chk(v == 0, "R7 pre locked", v, 0);
        bus_wr(3'd2, 16'd10);
        bus_rd(3'd2, v); chk(v == FULL, "R7 rld locked", v, FULL);

        // R8 other key keeps unlock; R9 busy set and clear
        bus_wr(3'd0, 16'h5555);
        bus_wr(3'd0, 16'h1234);
        bus_wr(3'd1, 16'd1);
        bus_rd(3'd4, v); chk(v == 1, "R9 pre busy", v, 1);
        wait_idle("R9 pre clear");
        bus_rd(3'd1, v); chk(v == 1, "R7 pre unlocked", v, 1);
        bus_wr(3'd2, 16'd9);
        bus_wr(3'd2, 16'd20);
        bus_rd(3'd4, v); chk(v == 2, "R9 rld busy", v, 2);
        wait_idle("R9 rld clear");
        bus_rd(3'd2, v); chk(v == 9, "R9 write while busy", v, 9);
        bus_wr(3'd0, 16'hAAAA);
        bus_wr(3'd1, 16'd3);
        bus_rd(3'd1, v); chk(v == 1, "R8 refresh relocks", v, 1);
        bus_wr(3'd0, 16'h5555);
        bus_wr(3'd0, 16'hCCCC);
        bus_wr(3'd2, 16'd30);
        bus_rd(3'd2, v); chk(v == 9, "R8 start relocks", v, 9);

        // R6 / R5 prescaler and reload sweep, exact expiry period
        for (int code = 0; code < 8; code++) begin
            for (int ri = 0; ri < 2; ri++) begin
                cfg(code, ri * 5);
                dv = 4 << ((code > 6) ? 6 : code);
                ex = (ri * 5 + 1) * dv * 4;
                rise_after(ex * 2 + 100, n);
                rise_after(ex * 2 + 100, n);
                rise_after(ex * 2 + 100, n);
                chk(n >= ex - 1 && n <= ex + 1, $sformatf("R6 R5 code=%0d", code), n, ex);
            end
        end

        // R5 regular refresh prevents expiry
        cfg(0, 20);
        repeat (60) step();
        for (int k = 0; k < 5; k++) begin
            bus_wr(3'd0, 16'hAAAA);
            rise_after(200, n); chk(n == -1, "R5 refresh keeps alive", n, -1);
        end

        // R10 window
        bus_wr(3'd3, 16'd3);
        wait_idle("R9 win");
        bus_rd(3'd3, v); chk(v == 3, "R10 window unlocked", v, 3);
        bus_wr(3'd0, 16'hAAAA);
        t0 = cyc;
        rise_after(60, n); chk(n > 0, "R10 early refresh", n, 1);
        while (cyc < t0 + 300) step();
        bus_wr(3'd0, 16'hAAAA);
        rise_after(250, n); chk(n == -1, "R10 late refresh", n, -1);
        bus_wr(3'd0, 16'hAAAA);
        rise_after(60, n); chk(n > 0, "R10 early again", n, 1);
        bus_wr(3'd3, 16'(FULL));
        wait_idle("R9 win");
        repeat (40) step();
        bus_wr(3'd0, 16'hAAAA);
        rise_after(200, n); chk(n == -1, "R10 window off", n, -1);

        // R3 hardware start
        do_reset(1);
        ex = (FULL + 1) * 4 * 4;
        rise_after(2000, n); chk(n >= ex - 8 && n <= ex + 36, "R3 hw start", n, ex);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            vecs++; miss++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end
endmodule